// File: doc/BRIEF.md
# Floppy Controller Programmed-I/O Front End

This block is the register front end of a floppy controller on a CPU I/O bus. It answers eight consecutive device addresses. It holds a status word, a two-part command-block pointer and one interrupt request line. A write to the control-word address does one of four things: it starts a command, it runs the test path, it enables interrupts, or it clears the device. Only one of these happens per write, chosen by a fixed priority. Software first writes the pointer halves so that they locate a command block in memory. It then writes the control word with the fetch bit set. The back-end engine reads the block, does the transfer and returns a done pulse.

Starting a command drops "ready" and raises "active". Completion reverses both and raises the interrupt line if interrupts are enabled. Enabling interrupts while the device is already ready and not yet enabled raises the interrupt line at once. The interrupt line is a level. It stays high until the next control-word write. A control word that asks for nothing the block recognizes produces a one-cycle illegal-access flag.

All state changes take effect at the clock edge that samples the write or the done pulse. The pulses to the engine and the illegal flag are registered and last exactly one cycle.

Top module: `fdc_pio_front`

## Requirements
- R1: After reset the status word reads 0xC008 (bits 15:14 dual-density, bit 3 ready), the interrupt line is low and the pointer output is zero.
- R2: Reading offset 2 returns the status word. Every other offset (0, 1, 3, 4, 5, 6, 7) reads as zero. Status bits: 1 interrupts enabled, 2 active, 3 ready, 4 any error, 6 hard transfer error, 15:14 dual-density.
- R3: A write to offset 5 loads the high pointer and a write to offset 7 loads the low pointer. The pointer output equals low + (high[7:0] << 8) as a 17-bit sum, and high[15:8] has no effect.
- R4: A control word (offset 3) with bit 8 set and bit 3 clear gives a one-cycle start pulse. It clears ready, sets active, and clears both error bits.
- R5: A control word with bit 3 set gives a one-cycle test pulse and no start pulse, whatever its other bits. It leaves the status word unchanged.
- R6: A control word with bit 1 set and bits 3 and 8 clear sets the interrupt-enabled bit. The interrupt line rises only if, before the write, ready was 1 and interrupt-enabled was 0.
- R7: A done pulse clears active and sets ready, and it raises the interrupt line when interrupts are enabled. If the hard-error input is high with done, bits 6 and 4 are set.
- R8: A control word whose only recognized bit is bit 4 (clear) changes no status bit and gives no illegal flag.
- R9: A control word with none of bits 1, 3, 4 or 8 set (for example only bits 2 and 5) gives a one-cycle illegal flag and changes no status bit. The start, test and illegal pulses are never high together.
- R10: The interrupt line holds its level until a control-word write. That write drops it unless the same cycle raises it again.
- R11: When a done pulse and a control-word write fall in the same cycle, the interrupt raised by the done (judged with the enable value after the write) wins over the write's clearing. A start in that cycle wins over done for ready and active.
- R12: Writes to offsets 0, 1, 2, 4 and 6 change neither the status word, the interrupt line nor the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Register offset within the device's eight addresses |
| busWr | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for busAddr (combinational) |
| engDone | input | 1 | Completion pulse from the transfer engine |
| engHardErr | input | 1 | Hard transfer error, valid with engDone |
| engStart | output | 1 | One-cycle command start pulse to the engine |
| engTest | output | 1 | One-cycle test-path pulse to the engine |
| cbPtr | output | 17 | Command-block physical address |
| irqReq | output | 1 | Interrupt request level |
| illegalPulse | output | 1 | One-cycle flag for an unrecognized control word |

## Verification
A done pulse from the engine can arrive in the same cycle as a control-word write. The bench provokes this twice. Once it pairs a fresh start with done while interrupts are enabled. Once it pairs an interrupt-enable write with done while the device is busy. In both cases it then reads the status word and the interrupt line and compares them with values derived from R11. Start must win ready and active. The interrupt line must be high even though a control write would otherwise drop it.

// File: rtl/fdc_pio_pkg.sv
package fdc_pio_pkg;
  // register offsets within the eight-address window
  localparam int OFS_STATUS = 2;
  localparam int OFS_CTRL   = 3;
  localparam int OFS_PTR_HI = 5;
  localparam int OFS_PTR_LO = 7;

  // control word bit positions
  localparam int CW_IE    = 1;
  localparam int CW_TEST  = 3;
  localparam int CW_CLEAR = 4;
  localparam int CW_FETCH = 8;

  // status word bit positions
  localparam int ST_IE     = 1;
  localparam int ST_ACTIVE = 2;
  localparam int ST_READY  = 3;
  localparam int ST_ERR    = 4;
  localparam int ST_HARD   = 6;

  typedef struct packed {
    logic cwWrite;
    logic start;
    logic test;
    logic ieSet;
    logic clearNop;
    logic illegal;
    logic ptrHiWr;
    logic ptrLoWr;
  } ctrlStrobe_t;
endpackage

// File: rtl/fdc_pio_ctrl.sv
module fdc_pio_ctrl
  import fdc_pio_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output ctrlStrobe_t       strb
);
  // Decode a bus write into exactly one action strobe (plus cwWrite marker).
  always_comb begin
    strb = '0;
    if (busWr) begin
      if (busAddr == ADDR_W'(OFS_CTRL)) begin
        strb.cwWrite = 1'b1;
        // fixed priority: test > fetch/execute > interrupt enable > clear
        if (busWdata[CW_TEST])       strb.test     = 1'b1;
        else if (busWdata[CW_FETCH]) strb.start    = 1'b1;
        else if (busWdata[CW_IE])    strb.ieSet    = 1'b1;
        else if (busWdata[CW_CLEAR]) strb.clearNop = 1'b1;
        else                         strb.illegal  = 1'b1;
      end else if (busAddr == ADDR_W'(OFS_PTR_HI)) begin
        strb.ptrHiWr = 1'b1;
      end else if (busAddr == ADDR_W'(OFS_PTR_LO)) begin
        strb.ptrLoWr = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fdc_pio_dp.sv
module fdc_pio_dp
  import fdc_pio_pkg::*;
#(
  parameter int ADDR_W       = 3,
  parameter int DATA_W       = 16,
  parameter int HI_KEEP      = 8,
  parameter int PTR_SHIFT    = 8,
  parameter bit DUAL_DENSITY = 1'b1,
  localparam int PTR_W       = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              engDone,
  input  logic              engHardErr,
  output logic [DATA_W-1:0] rdata,
  output logic [PTR_W-1:0]  cbPtr,
  output logic              irqReq,
  output logic              engStart,
  output logic              engTest,
  output logic              illegalPulse
);
  logic stReady, stActive, stIe, stErr, stHard;
  logic nReady, nActive, nIe, nErr, nHard, nIrq, irqSet;
  logic [DATA_W-1:0] ptrHi, ptrLo;
  logic [DATA_W-1:0] statusWord;
  logic unusedPtrHi;

  assign unusedPtrHi = ^ptrHi[DATA_W-1:HI_KEEP];

  // status word assembly
  always_comb begin
    statusWord            = '0;
    statusWord[ST_IE]     = stIe;
    statusWord[ST_ACTIVE] = stActive;
    statusWord[ST_READY]  = stReady;
    statusWord[ST_ERR]    = stErr;
    statusWord[ST_HARD]   = stHard;
    statusWord[DATA_W-1]  = DUAL_DENSITY;
    statusWord[DATA_W-2]  = DUAL_DENSITY;
  end

  // next-state merge: done applied first, then the control action
  always_comb begin
    nReady  = stReady;
    nActive = stActive;
    nIe     = stIe;
    nErr    = stErr;
    nHard   = stHard;
    irqSet  = 1'b0;
    if (engDone) begin
      nActive = 1'b0;
      nReady  = 1'b1;
      if (engHardErr) begin
        nHard = 1'b1;
        nErr  = 1'b1;
      end
    end
    if (strb.start) begin
      nReady  = 1'b0;
      nActive = 1'b1;
      nHard   = 1'b0;
      nErr    = 1'b0;
    end
    if (strb.ieSet) begin
      if (stReady && !stIe) irqSet = 1'b1;
      nIe = 1'b1;
    end
    if (engDone && nIe) irqSet = 1'b1;
    if (irqSet)            nIrq = 1'b1;
    else if (strb.cwWrite) nIrq = 1'b0;
    else                   nIrq = irqReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stReady      <= 1'b1;
      stActive     <= 1'b0;
      stIe         <= 1'b0;
      stErr        <= 1'b0;
      stHard       <= 1'b0;
      irqReq       <= 1'b0;
      engStart     <= 1'b0;
      engTest      <= 1'b0;
      illegalPulse <= 1'b0;
      ptrHi        <= '0;
      ptrLo        <= '0;
    end else begin
      stReady      <= nReady;
      stActive     <= nActive;
      stIe         <= nIe;
      stErr        <= nErr;
      stHard       <= nHard;
      irqReq       <= nIrq;
      engStart     <= strb.start;
      engTest      <= strb.test;
      illegalPulse <= strb.illegal;
      if (strb.ptrHiWr) ptrHi <= busWdata;
      if (strb.ptrLoWr) ptrLo <= busWdata;
    end
  end

  assign cbPtr = PTR_W'(ptrLo) + (PTR_W'(ptrHi[HI_KEEP-1:0]) << PTR_SHIFT);
  assign rdata = (rdAddr == ADDR_W'(OFS_STATUS)) ? statusWord : '0;

  // R4
  p_start_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.start |=> stActive && !stReady);
  // R7
  p_done_ready_r7: assert property (@(posedge clk) disable iff (!rstN)
    engDone && !strb.start |=> stReady && !stActive);
  // R5
  p_test_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.test && !engDone |=> $stable(statusWord) && !engStart);
  // R6
  p_irq_needs_ie_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> stIe);
  // R8
  p_clear_nop_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearNop && !engDone |=> $stable(statusWord) && !illegalPulse);
  // R9
  p_pulses_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({engStart, engTest, illegalPulse}));
  // R10
  p_irq_drop_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.cwWrite && !strb.ieSet && !engDone |=> !irqReq);
  p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cwWrite && !engDone |=> $stable(irqReq));
  // R11
  p_done_irq_r11: assert property (@(posedge clk) disable iff (!rstN)
    engDone && stIe |=> irqReq);
  // R12
  p_unused_wr_r12: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cwWrite && !engDone |=> $stable(statusWord));
endmodule

// File: rtl/fdc_pio_front.sv
module fdc_pio_front
  import fdc_pio_pkg::*;
#(
  parameter int ADDR_W       = 3,
  parameter int DATA_W       = 16,
  parameter int HI_KEEP      = 8,
  parameter int PTR_SHIFT    = 8,
  parameter bit DUAL_DENSITY = 1'b1,
  localparam int PTR_W       = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              engDone,
  input  logic              engHardErr,
  output logic              engStart,
  output logic              engTest,
  output logic [PTR_W-1:0]  cbPtr,
  output logic              irqReq,
  output logic              illegalPulse
);
  ctrlStrobe_t strb;

  fdc_pio_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .busAddr (busAddr),
    .busWr   (busWr),
    .busWdata(busWdata),
    .strb    (strb)
  );

  fdc_pio_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HI_KEEP(HI_KEEP),
    .PTR_SHIFT(PTR_SHIFT), .DUAL_DENSITY(DUAL_DENSITY)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .busWdata    (busWdata),
    .rdAddr      (busAddr),
    .engDone     (engDone),
    .engHardErr  (engHardErr),
    .rdata       (busRdata),
    .cbPtr       (cbPtr),
    .irqReq      (irqReq),
    .engStart    (engStart),
    .engTest     (engTest),
    .illegalPulse(illegalPulse)
  );
endmodule

// File: tb/tb_fdc_pio_front.sv
`timescale 1ns/1ps
module tb_fdc_pio_front;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = 3'd0;
  logic        busWr = 1'b0;
  logic [15:0] busWdata = 16'h0;
  logic [15:0] busRdata;
  logic        engDone = 1'b0;
  logic        engHardErr = 1'b0;
  logic        engStart, engTest, irqReq, illegalPulse;
  logic [16:0] cbPtr;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  fdc_pio_front dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .engDone(engDone),
    .engHardErr(engHardErr), .engStart(engStart), .engTest(engTest),
    .cbPtr(cbPtr), .irqReq(irqReq), .illegalPulse(illegalPulse)
  );

  // vector: {addr, wr, wdata, done, hardErr, expStatus, expIrq}
  localparam int NVEC = 13;
  localparam logic [38:0] VEC [NVEC] = '{
    {3'd3, 1'b1, 16'h0002, 1'b0, 1'b0, 16'hC00A, 1'b1},
    {3'd3, 1'b1, 16'h0100, 1'b0, 1'b0, 16'hC006, 1'b0},
    {3'd0, 1'b0, 16'h0000, 1'b1, 1'b0, 16'hC00A, 1'b1},
    {3'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 16'hC00A, 1'b1},
    {3'd3, 1'b1, 16'h0010, 1'b0, 1'b0, 16'hC00A, 1'b0},
    {3'd3, 1'b1, 16'h0100, 1'b0, 1'b0, 16'hC006, 1'b0},
    {3'd0, 1'b0, 16'h0000, 1'b1, 1'b1, 16'hC05A, 1'b1},
    {3'd3, 1'b1, 16'h0108, 1'b0, 1'b0, 16'hC05A, 1'b0},
    {3'd3, 1'b1, 16'h0100, 1'b0, 1'b0, 16'hC006, 1'b0},
    {3'd0, 1'b1, 16'hFFFF, 1'b0, 1'b0, 16'hC006, 1'b0},
    {3'd2, 1'b1, 16'hFFFF, 1'b0, 1'b0, 16'hC006, 1'b0},
    {3'd3, 1'b1, 16'h0100, 1'b1, 1'b0, 16'hC006, 1'b1},
    {3'd3, 1'b1, 16'h0024, 1'b0, 1'b0, 16'hC006, 1'b0}
  };
  string vTag [NVEC] = '{"R6", "R4", "R7", "R10", "R8", "R4", "R7",
                         "R5", "R4", "R12", "R12", "R11", "R9"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    busWr = 1'b0;
    engDone = 1'b0;
    engHardErr = 1'b0;
  endtask

  // drive one cycle, return at the following falling edge
  task automatic cyc(input logic [2:0] a, input logic w, input logic [15:0] d,
                     input logic dn, input logic he);
    @(negedge clk);
    busAddr = a; busWr = w; busWdata = d; engDone = dn; engHardErr = he;
    @(negedge clk);
    idle();
  endtask

  task automatic readStatus(output logic [15:0] s);
    busAddr = 3'd2;
    #0.5;
    s = busRdata;
  endtask

  task automatic doReset();
    idle();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] st;
    doReset();
    // R1 reset state
    readStatus(st);
    chk("R1 status", st, 16'hC008);
    chk("R1 irq", irqReq, 0);
    chk("R1 ptr", cbPtr, 0);
    // R2 read map
    for (int a = 0; a < 8; a++) begin
      if (a != 2) begin
        busAddr = 3'(a);
        #0.5;
        chk("R2 unused read", busRdata, 0);
      end
    end

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [38:0] v;
      v = VEC[i];
      cyc(v[38:36], v[35], v[34:19], v[18], v[17]);
      readStatus(st);
      chk({vTag[i], " status"}, st, v[16:1]);
      chk({vTag[i], " irq"}, irqReq, v[0]);
    end

    // directed: start pulse shape and busy IE write
    doReset();
    cyc(3'd3, 1'b1, 16'h0100, 1'b0, 1'b0);
    chk("R4 start pulse", engStart, 1);
    readStatus(st);
    chk("R4 status", st, 16'hC004);
    @(negedge clk);
    chk("R4 start one cycle", engStart, 0);
    cyc(3'd3, 1'b1, 16'h0002, 1'b0, 1'b0);
    readStatus(st);
    chk("R6 no irq when busy", irqReq, 0);
    chk("R6 ie set", st, 16'hC006);
    // R11: IE write with done in the same cycle
    cyc(3'd3, 1'b1, 16'h0002, 1'b1, 1'b0);
    readStatus(st);
    chk("R11 irq wins", irqReq, 1);
    chk("R11 status", st, 16'hC00A);
    @(negedge clk);
    chk("R10 irq held", irqReq, 1);
    cyc(3'd3, 1'b1, 16'h0002, 1'b0, 1'b0);
    chk("R6 no refire when enabled", irqReq, 0);

    // R5 test pulse
    cyc(3'd3, 1'b1, 16'h0108, 1'b0, 1'b0);
    chk("R5 test pulse", engTest, 1);
    chk("R5 no start", engStart, 0);
    @(negedge clk);
    chk("R5 test one cycle", engTest, 0);

    // R9 / R8 illegal flag
    cyc(3'd3, 1'b1, 16'h0000, 1'b0, 1'b0);
    chk("R9 illegal pulse", illegalPulse, 1);
    @(negedge clk);
    chk("R9 illegal one cycle", illegalPulse, 0);
    cyc(3'd3, 1'b1, 16'h0010, 1'b0, 1'b0);
    chk("R8 clear not illegal", illegalPulse, 0);
    readStatus(st);
    chk("R8 status kept", st, 16'hC00A);

    // R3 pointer
    cyc(3'd5, 1'b1, 16'hAB12, 1'b0, 1'b0);
    cyc(3'd7, 1'b1, 16'hFFFF, 1'b0, 1'b0);
    chk("R3 pointer carry", cbPtr, 17'h111FF);
    cyc(3'd6, 1'b1, 16'h0000, 1'b0, 1'b0);
    cyc(3'd4, 1'b1, 16'h0000, 1'b0, 1'b0);
    cyc(3'd1, 1'b1, 16'h0000, 1'b0, 1'b0);
    chk("R12 pointer kept", cbPtr, 17'h111FF);
    cyc(3'd5, 1'b1, 16'h00FF, 1'b0, 1'b0);
    cyc(3'd7, 1'b1, 16'h0001, 1'b0, 1'b0);
    chk("R3 pointer sum", cbPtr, 17'h0FF01);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule